// File: doc/BRIEF.md
# Multi-Channel Shared-Counter PWM Timer

This block produces edge-aligned pulse-width-modulated outputs on several channels. One up-counter, slowed by a power-of-two prescaler, is shared by every channel. A modulo value sets the period: the counter runs from zero up to the modulo and then returns to zero. Each channel compares the count with its own compare value to form its duty cycle. A two-bit level field sets each channel's polarity and enable.

Software reaches all state through a simple synchronous register bus. A write is sampled on the clock edge where `bus_wr` is high, and a read is combinational on `bus_addr`. When the counter is stopped, writes to the modulo and to a compare value take effect at once. When the counter is running, these writes are held and applied at the next period start. A read returns the value in effect, so software can poll until a held write has been applied. Each channel also has a match flag that sets when the count reaches its compare value and is cleared by writing one to it.

Top module: `pwm_shared_timer`

## Requirements
- R1: Offset 0x04 reads the channel count in bits 7:0 and zero in all other bits. Writes to it have no effect.
- R2: While the counter mode field is 01, the count advances by one every 2^P clocks, where P is control bits 2:0 at offset 0x10.
- R3: After reset the count, modulo, control and all channel registers read zero. While running, the count goes from 0 up to the modulo and then returns to 0, giving modulo+1 ticks per period. Any mode other than 01 freezes the count.
- R4: While the mode field (control bits 4:3) is 00, a write to the modulo (0x18, 16 bits) or to channel n's compare value (0x24+8n, 16 bits) takes effect in the next cycle, for readback and for the outputs.
- R5: While the mode is not 00, modulo and compare writes are held. They take effect on the tick where the count returns from the modulo to 0. Until then, reads return the old values.
- R6: A modulo write while stopped leaves the count unchanged. Any write to offset 0x14 sets the count to 0.
- R7: Channel n control is at 0x20+8n. With bit 5 set and level field bits 3:2 equal to 10, the output is high while count < compare value and low otherwise. A compare value of 0 gives a constant low, and a value above the modulo gives a constant high.
- R8: A level field of 01 gives the complement of R7. The reserved value 11 behaves like 10.
- R9: An output is driven only when control bit 5 is 1 and the level field is nonzero; otherwise it is 0. Bit 4 is stored and read back but has no effect on the output. Control changes reach the output in the cycle after the write, with no wait for a period boundary.
- R10: Control bit 7 is the match flag. It sets on every clock where the mode is 01 and the count equals the channel's compare value in effect. Writing 1 to bit 7 clears it, and writing 0 leaves it; if a set and a clear fall in the same cycle, the set wins.
- R11: Control at 0x10 reads back bits 4:0 and zero above them. Offset 0x08 and every other unmapped offset read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Four channels run at the same time with different settings:
- normal polarity with a mid-range compare value;
- inverted polarity with a compare value of zero;
- a compare value above the modulo;
- the reserved level code.

Together these separate the compare direction, the polarity inversion and the two saturated cases in every period. The prescaler is run at exponents 0, 2 and 7, which tells a per-clock count apart from a divided one and exercises the divider's full range. Modulo and compare writes are issued both while stopped and mid-period while running. This separates immediate from held updates. It also shows whether held values land exactly at the wrap tick.

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int PS_W   = 3;
  localparam int PRE_W  = (1 << PS_W) - 1;
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_END = 32 + 8 * NUM_CH;
  localparam logic [7:0] A_INFO = 8'h04;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_CNT  = 8'h14;
  localparam logic [7:0] A_MOD  = 8'h18;
  localparam logic [7:0] A_CH0  = 8'h20;

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       mode_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, mod_buf, mod_act;
  logic [NUM_CH-1:0][CNT_W-1:0] val_buf, val_act;
  logic [NUM_CH-1:0][1:0] els_q;
  logic [NUM_CH-1:0] msb_q, msa_q, flag_q, ch_en;

  logic running, stopped, tick, wrap, cnt_wr, mod_wr, ctrl_wr;
  logic [7:0] ch_off;
  logic [IDX_W-1:0] ch_sel;
  logic ch_hit, ch_is_val;
  logic unused_bits;

  assign running = (mode_q == 2'b01);
  assign stopped = (mode_q == 2'b00);
  assign tick    = running && (pre_q == ((PRE_W'(1) << ps_q) - PRE_W'(1)));
  assign wrap    = tick && (cnt_q == mod_act);
  assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
  assign mod_wr  = bus_wr && (bus_addr == A_MOD);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  assign ch_off    = bus_addr - A_CH0;
  assign ch_sel    = ch_off[3 +: IDX_W];
  assign ch_is_val = ch_off[2];
  assign ch_hit    = (bus_addr[1:0] == 2'b00) && (bus_addr >= A_CH0) &&
                     ({1'b0, bus_addr} < 9'(CH_END));
  assign unused_bits = ^{bus_wdata[31:CNT_W], ch_off};

  // R2 R3 R6: prescaler and shared counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_wr) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (running) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end else begin
      pre_q <= '0;
    end
  end

  // R4 R5 R11: control and buffered modulo
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      mode_q  <= '0;
      mod_buf <= '0;
      mod_act <= '0;
    end else begin
      if (ctrl_wr) begin
        ps_q   <= bus_wdata[2:0];
        mode_q <= bus_wdata[4:3];
      end
      if (wrap) mod_act <= mod_buf;
      if (mod_wr) begin
        mod_buf <= bus_wdata[CNT_W-1:0];
        if (stopped) mod_act <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel, cw, vw, below;
    assign sel = ch_hit && (ch_sel == IDX_W'(i));
    assign cw  = bus_wr && sel && !ch_is_val;
    assign vw  = bus_wr && sel && ch_is_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_buf[i] <= '0;
        val_act[i] <= '0;
        msb_q[i]   <= 1'b0;
        msa_q[i]   <= 1'b0;
        els_q[i]   <= 2'b00;
        flag_q[i]  <= 1'b0;
      end else begin
        if (wrap) val_act[i] <= val_buf[i];
        if (vw) begin
          val_buf[i] <= bus_wdata[CNT_W-1:0];
          if (stopped) val_act[i] <= bus_wdata[CNT_W-1:0];
        end
        if (cw) begin
          msb_q[i] <= bus_wdata[5];
          msa_q[i] <= bus_wdata[4];
          els_q[i] <= bus_wdata[3:2];
        end
        // R10: set has priority over write-one-to-clear
        if (running && (cnt_q == val_act[i])) flag_q[i] <= 1'b1;
        else if (cw && bus_wdata[7])          flag_q[i] <= 1'b0;
      end
    end

    // R7 R8 R9
    assign below      = (cnt_q < val_act[i]);
    assign ch_en[i]   = msb_q[i] && (els_q[i] != 2'b00);
    assign pwm_out[i] = ch_en[i] && (below ^ (els_q[i] == 2'b01));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_INFO)      bus_rdata = 32'(NUM_CH);
    else if (bus_addr == A_CTRL) bus_rdata = {27'b0, mode_q, ps_q};
    else if (bus_addr == A_CNT)  bus_rdata = 32'(cnt_q);
    else if (bus_addr == A_MOD)  bus_rdata = 32'(mod_act);
    else if (ch_hit) begin
      if (ch_is_val) bus_rdata = 32'(val_act[ch_sel]);
      else bus_rdata = {24'b0, flag_q[ch_sel], 1'b0, msb_q[ch_sel],
                        msa_q[ch_sel], els_q[ch_sel], 2'b00};
    end
  end
endmodule

// File: rtl/pwm_shared_timer_chk.sv
module pwm_shared_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [CNT_W-1:0]  wr_low,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [1:0]        mode_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mod_act,
  input logic [NUM_CH-1:0] ch_en
);
  assert_param_ro_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h04) |-> (bus_rdata == 32'(NUM_CH)));

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b01 && !(bus_wr && bus_addr == 8'h14)) |=> (cnt_q == $past(cnt_q)));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != $past(cnt_q)) && !$past(bus_wr && bus_addr == 8'h14)) |->
    ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) ||
     (cnt_q == '0 && $past(cnt_q) == $past(mod_act))));

  assert_stopped_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h18 && mode_q == 2'b00) |=> (mod_act == $past(wr_low)));

  assert_held_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_act != $past(mod_act)) |-> ((cnt_q == '0) || ($past(mode_q) == 2'b00)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_disabled_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !pwm_out[i]);
  end
endmodule

bind pwm_shared_timer pwm_shared_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wr_low(bus_wdata[CNT_W-1:0]), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .mode_q(mode_q), .cnt_q(cnt_q), .mod_act(mod_act), .ch_en(ch_en)
);

// File: tb/sim_pwm_shared_timer.sv
`timescale 1ns/1ps
module sim_pwm_shared_timer;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pwm_out;

  always #2.5 clk = ~clk;

  pwm_shared_timer #(.NUM_CH(N), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R3";

  // behavioural reference
  int m_ps, m_mode, m_pre, m_cnt, m_modb, m_moda;
  int m_vb[N], m_va[N], m_msb[N], m_msa[N], m_els[N], m_flag[N];
  bit m_run, m_tick, m_wrap;

  function automatic int ch_of(logic [7:0] a);
    if (a >= 8'h20 && int'(a) < 32 + 8 * N && a[1:0] == 2'b00) return (int'(a) - 32) / 8;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int c;
    c = ch_of(a);
    if (a == 8'h04) return 32'(N);
    if (a == 8'h10) return 32'((m_mode << 3) | m_ps);
    if (a == 8'h14) return 32'(m_cnt);
    if (a == 8'h18) return 32'(m_moda);
    if (c >= 0) begin
      if (a[2]) return 32'(m_va[c]);
      return 32'((m_flag[c] << 7) | (m_msb[c] << 5) | (m_msa[c] << 4) | (m_els[c] << 2));
    end
    return 32'd0;
  endfunction

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (m_msb[i] != 0 && m_els[i] != 0) && ((m_cnt < m_va[i]) ^ (m_els[i] == 1));
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_mode = 0; m_pre = 0; m_cnt = 0; m_modb = 0; m_moda = 0;
      for (int i = 0; i < N; i++) begin
        m_vb[i] = 0; m_va[i] = 0; m_msb[i] = 0; m_msa[i] = 0; m_els[i] = 0; m_flag[i] = 0;
      end
    end else begin
      m_run  = (m_mode == 1);
      m_tick = m_run && (m_pre == (1 << m_ps) - 1);
      m_wrap = m_tick && (m_cnt == m_moda);
      for (int i = 0; i < N; i++) begin
        if (m_run && m_cnt == m_va[i]) m_flag[i] = 1;
        else if (bus_wr && ch_of(bus_addr) == i && !bus_addr[2] && bus_wdata[7]) m_flag[i] = 0;
      end
      if (bus_wr && bus_addr == 8'h14) begin
        m_cnt = 0; m_pre = 0;
      end else if (m_run) begin
        if (m_tick) begin
          m_pre = 0;
          m_cnt = m_wrap ? 0 : (m_cnt + 1) & 'hFFFF;
        end else m_pre = m_pre + 1;
      end else m_pre = 0;
      if (m_wrap) begin
        m_moda = m_modb;
        for (int i = 0; i < N; i++) m_va[i] = m_vb[i];
      end
      if (bus_wr) begin
        if (bus_addr == 8'h10) begin
          m_ps = int'(bus_wdata[2:0]); m_mode = int'(bus_wdata[4:3]);
        end else if (bus_addr == 8'h18) begin
          m_modb = int'(bus_wdata[15:0]);
          if (m_mode == 0) m_moda = m_modb;
        end else if (ch_of(bus_addr) >= 0) begin
          if (bus_addr[2]) begin
            m_vb[ch_of(bus_addr)] = int'(bus_wdata[15:0]);
            if (m_mode == 0) m_va[ch_of(bus_addr)] = m_vb[ch_of(bus_addr)];
          end else begin
            m_msb[ch_of(bus_addr)] = int'(bus_wdata[5]);
            m_msa[ch_of(bus_addr)] = int'(bus_wdata[4]);
            m_els[ch_of(bus_addr)] = int'(bus_wdata[3:2]);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (pwm_out !== exp_out()) begin
        n_bad++;
        $display("FAIL %s: pwm_out=%0h expected %0h at t=%0t", phase, pwm_out, exp_out(), $time);
      end
      n_cmp++;
      if (bus_rdata !== exp_rd(bus_addr)) begin
        n_bad++;
        $display("FAIL %s: rdata[%0h]=%0h expected %0h at t=%0t", phase, bus_addr,
                 bus_rdata, exp_rd(bus_addr), $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n, logic [7:0] a);
    bus_addr = a;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
    end
  end

  logic [31:0] c1;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rdchk("R3 count after reset", 8'h14, 0);
    chk("R3 outputs after reset", 32'(pwm_out), 0);
    phase = "R1";
    rdchk("R1 info", 8'h04, 4);
    wr(8'h04, 32'hFF);
    rdchk("R1 info after write", 8'h04, 4);
    phase = "R4";
    wr(8'h18, 9);
    rdchk("R4 modulo immediate", 8'h18, 9);
    wr(8'h24, 3);
    rdchk("R4 value immediate", 8'h24, 3);
    wr(8'h20, 32'h28);
    wr(8'h2C, 0);  wr(8'h28, 32'h24);
    wr(8'h34, 20); wr(8'h30, 32'h28);
    wr(8'h3C, 5);  wr(8'h38, 32'h2C);
    rdchk("R9 control readback", 8'h20, 32'h28);
    bus_addr = 8'h14;
    @(negedge clk);
    chk("R7 R8 outputs at count 0", 32'(pwm_out), 32'hF);
    phase = "R3";
    wr(8'h10, 32'h08);
    idle(25, 8'h14);
    phase = "R5";
    wr(8'h18, 4);
    idle(3, 8'h18);
    wr(8'h24, 8);
    idle(20, 8'h24);
    rdchk("R5 held value applied", 8'h24, 8);
    rdchk("R5 held modulo applied", 8'h18, 4);
    phase = "R2";
    wr(8'h10, 32'h0A);
    idle(60, 8'h14);
    wr(8'h10, 32'h0F);
    idle(700, 8'h14);
    phase = "R10";
    wr(8'h10, 32'h08);
    idle(10, 8'h28);
    wr(8'h10, 0);
    rdchk("R10 flag set", 8'h28, 32'hA4);
    wr(8'h28, 32'h24);
    rdchk("R10 write 0 keeps flag", 8'h28, 32'hA4);
    wr(8'h28, 32'hA4);
    rdchk("R10 flag cleared", 8'h28, 32'h24);
    phase = "R7";
    wr(8'h24, 0);
    bus_addr = 8'h14; @(negedge clk);
    chk("R7 value 0 low", 32'(pwm_out[0]), 0);
    phase = "R9";
    wr(8'h20, 32'h18);
    wr(8'h30, 32'h20);
    bus_addr = 8'h14; @(negedge clk);
    chk("R9 no mode bit low", 32'(pwm_out[0]), 0);
    chk("R9 level 00 low", 32'(pwm_out[2]), 0);
    chk("R8 level 11 as normal", 32'(pwm_out[3]), 1);
    phase = "R6";
    wr(8'h18, 9);
    wr(8'h10, 32'h08);
    idle(8, 8'h14);
    wr(8'h10, 0);
    bus_addr = 8'h14; @(negedge clk);
    c1 = bus_rdata;
    wr(8'h18, 2);
    rdchk("R6 count kept on modulo write", 8'h14, c1);
    rdchk("R4 modulo immediate when stopped", 8'h18, 2);
    wr(8'h14, 32'h1234);
    rdchk("R6 count cleared", 8'h14, 0);
    phase = "R11";
    rdchk("R11 global offset zero", 8'h08, 0);
    rdchk("R11 unmapped offset zero", 8'h1C, 0);
    wr(8'h10, 32'h3F);
    rdchk("R11 control readback", 8'h10, 32'h1F);
    wr(8'h30, 32'h28);
    idle(10, 8'h14);
    wr(8'h10, 0);
    phase = "R3";
    wr(8'h10, 32'h08);
    idle(30, 8'h14);
    summary();
  end
endmodule